// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Recency Replacement

This block is a read-only lookup cache. Every line holds one 32-bit word, and every set holds two such lines (ways). A requester presents a byte address with a one-cycle strobe. One cycle later the block answers with a hit flag, the cached word and a way number. The two lowest address bits pick a byte inside the word and play no part in the lookup. The bits just above them pick the set, which is the word address modulo the number of sets. All the remaining upper bits form the tag. The number of sets is a parameter and must be a power of two, at least two.

On a miss the block holds the missed set, tag and chosen way. It then waits for the backing store to present the word on the fill port. One fill cycle writes the tag, the data and the valid bit, and marks the filled way as recently used. Each set keeps one recency bit, which every hit and every fill rewrites. Because of that bit, two addresses that share a set can live in the cache together. Without it they would evict each other on every alternate access.

Top module: `tw_lookup_cache`

## Requirements
- R1: Address bits [1:0] are ignored in the lookup. Any byte address inside a cached word hits and returns that same word.
- R2: The set index is addr[SET_W+1:2] and the tag is addr[31:SET_W+2]. Two tags in one set can be resident at the same time. Traffic to one set leaves the lines of every other set unchanged.
- R3: A hit is reported when a valid way of the indexed set holds the request tag. resp_data is that way's word and resp_way is that way's number. On a miss resp_data is zero.
- R4: After reset every line is invalid, so the first reference to any address misses. resp_valid is low during reset and after it.
- R5: Each hit and each fill marks the referenced way as the set's most recent way.
- R6: When both ways of the set are valid, a miss selects the way not used most recently. That way is overwritten by the following fill.
- R7: A miss prefers an invalid way over the recency choice, and takes way 0 when both ways are invalid. On a miss, resp_way reports the way that the fill will write.
- R8: A fill cycle (fill_valid while a miss is pending) writes the tag, the word and the valid bit in that one cycle. A request in the next cycle hits.
- R9: resp_valid pulses for exactly one cycle, one cycle after an accepted request strobe. A request strobe is ignored while a fill is pending. fill_valid is ignored when no miss is pending.
- R10: With four sets, eight alternating references to word addresses 0 and 4 (byte addresses 0x0 and 0x10) produce exactly two misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup strobe, one cycle per request |
| req_addr | input | 32 | Byte address of the lookup |
| resp_valid | output | 1 | Result strobe, one cycle after an accepted request |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_way | output | 1 | Matching way on a hit, way to be filled on a miss |
| resp_data | output | 32 | Cached word on a hit, zero on a miss |
| fill_valid | input | 1 | Backing store presents the word for the pending miss |
| fill_data | input | 32 | Word written into the chosen way |

## Verification
The bench aims first at the replacement order. In that sequence a third tag enters a full set, and the address that was evicted is then looked up again. A design that kept the recency bit stale, or that updated it only on fills, would evict the wrong line and report a hit where a miss is due. Cold sets are checked for the choice of way 0 and for the preference for an invalid way. A design that followed only the recency bit would overwrite a valid line while an empty one was free.

Traffic to a second set confirms that the set index is taken from the right address bits. A request during a pending miss and a fill with no miss pending must both leave no trace, or a phantom response or a spurious line would appear. The alternating ping-pong string, replayed after a fresh reset, must cost exactly two misses. A direct-mapped slip would cost eight.

// File: rtl/tw_cache_pkg.sv
package tw_cache_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 32;
  localparam int BYTE_OFF = 2;
  localparam int NUM_WAYS = 2;

  // Registered result of one lookup.
  typedef struct packed {
    logic              hit;
    logic              way;
    logic [WORD_W-1:0] data;
  } lookup_res_t;
endpackage

// File: rtl/twc_way_store.sv
module twc_way_store #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic                    rd_valid,
  output logic [TAG_W-1:0]        rd_tag,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [DATA_W-1:0]       wr_data
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   valid_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_set] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Tag and data storage carry no reset; the valid bit qualifies them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = data_q[rd_set];

  // R8: a fill leaves the line valid with the written tag in the next cycle
  assert_fill_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_set)] && tag_q[$past(wr_set)] == $past(wr_tag)));
endmodule

// File: rtl/twc_recency.sv
module twc_recency #(
  parameter int SETS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] rd_set,
  output logic                    rd_mru,
  input  logic                    upd_en,
  input  logic [$clog2(SETS)-1:0] upd_set,
  input  logic                    upd_way
);
  // One bit per set: the way referenced most recently.
  logic [SETS-1:0] mru_q;
  logic [SETS-1:0] mru_d;

  always_comb begin
    mru_d = mru_q;
    if (upd_en) mru_d[upd_set] = upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mru_q <= '0;
    else        mru_q <= mru_d;
  end

  assign rd_mru = mru_q[rd_set];

  // R5: every referenced way becomes the most recent way of its set
  assert_mru_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (mru_q[$past(upd_set)] == $past(upd_way)));
endmodule

// File: rtl/twc_select.sv
module twc_select #(
  parameter int TAG_W = 28
) (
  input  logic [1:0]       way_valid,
  input  logic [TAG_W-1:0] tag0,
  input  logic [TAG_W-1:0] tag1,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             mru,
  output logic [1:0]       match,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way
);
  // Both ways compared in parallel.
  assign match[0] = way_valid[0] && (tag0 == req_tag);
  assign match[1] = way_valid[1] && (tag1 == req_tag);
  assign hit      = |match;
  assign hit_way  = match[1];

  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = ~mru;
  end
endmodule

// File: rtl/tw_lookup_cache.sv
module tw_lookup_cache
  import tw_cache_pkg::*;
#(
  parameter int SETS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic        resp_way,
  output logic [31:0] resp_data,
  input  logic        fill_valid,
  input  logic [31:0] fill_data
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - BYTE_OFF - SET_W;

  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  assign req_set = req_addr[BYTE_OFF +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

  // Pending-miss state
  logic             pend_q, pend_d;
  logic [SET_W-1:0] pend_set_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             pend_way_q;

  logic accept, fill_go;
  assign accept  = req_valid && !pend_q;
  assign fill_go = fill_valid && pend_q;

  // Way storage
  logic [1:0]        way_valid;
  logic [TAG_W-1:0]  way_tag  [NUM_WAYS];
  logic [WORD_W-1:0] way_data [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    twc_way_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(WORD_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (req_set),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_data  (way_data[w]),
      .wr_en    (fill_go && (pend_way_q == 1'(w))),
      .wr_set   (pend_set_q),
      .wr_tag   (pend_tag_q),
      .wr_data  (fill_data)
    );
  end

  // Recency
  logic             mru;
  logic             upd_en, upd_way;
  logic [SET_W-1:0] upd_set;

  always_comb begin
    upd_en  = 1'b0;
    upd_set = req_set;
    upd_way = 1'b0;
    if (fill_go) begin
      upd_en  = 1'b1;
      upd_set = pend_set_q;
      upd_way = pend_way_q;
    end else if (accept && hit) begin
      upd_en  = 1'b1;
      upd_way = hit_way;
    end
  end

  twc_recency #(.SETS(SETS)) u_recency (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (req_set),
    .rd_mru  (mru),
    .upd_en  (upd_en),
    .upd_set (upd_set),
    .upd_way (upd_way)
  );

  // Compare and victim choice
  logic [1:0] match;
  logic       hit, hit_way, victim_way;

  twc_select #(.TAG_W(TAG_W)) u_select (
    .way_valid  (way_valid),
    .tag0       (way_tag[0]),
    .tag1       (way_tag[1]),
    .req_tag    (req_tag),
    .mru        (mru),
    .match      (match),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  // Response next state
  lookup_res_t res_d, res_q;
  logic        rv_q;

  always_comb begin
    res_d.hit  = hit;
    res_d.way  = hit ? hit_way : victim_way;
    res_d.data = hit ? (hit_way ? way_data[1] : way_data[0]) : '0;
  end

  always_comb begin
    pend_d = pend_q;
    if (fill_go)             pend_d = 1'b0;
    else if (accept && !hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rv_q   <= accept;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q      <= '0;
      pend_set_q <= '0;
      pend_tag_q <= '0;
      pend_way_q <= 1'b0;
    end else begin
      if (accept) res_q <= res_d;
      if (accept && !hit) begin
        pend_set_q <= req_set;
        pend_tag_q <= req_tag;
        pend_way_q <= victim_way;
      end
    end
  end

  assign resp_valid = rv_q;
  assign resp_hit   = res_q.hit;
  assign resp_way   = res_q.way;
  assign resp_data  = res_q.data;

  // R3: a tag never sits in both ways of one set
  assert_one_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(match));
  // R9: accepted strobe answered in the next cycle
  assert_resp_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);
  // R9: no response while a fill is outstanding
  assert_quiet_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !resp_valid);
  // R6: a reported miss leaves a fill pending
  assert_miss_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> pend_q);
  // R7: a cold way 0 is always filled first
  assert_cold_way0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !way_valid[0]) |=> (!resp_hit && !resp_way));
endmodule

// File: tb/tw_lookup_cache_tb.sv
module tw_lookup_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;
  logic        resp_valid, resp_hit, resp_way;
  logic [31:0] resp_data;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  tw_lookup_cache #(.SETS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_data(resp_data), .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [31:0] dval(logic [31:0] a);
    return (a & ~32'h3) ^ 32'h5A00_C3E1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Issue one lookup and sample the response one edge later.
  task automatic lookup(logic [31:0] a, bit exp_hit, bit exp_way, string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid === 1'b1, req, "resp_valid", 32'(resp_valid), 1);
    check(resp_hit === exp_hit, req, "resp_hit", 32'(resp_hit), 32'(exp_hit));
    check(resp_way === exp_way, req, "resp_way", 32'(resp_way), 32'(exp_way));
    check(resp_data === (exp_hit ? dval(a) : 32'h0), req, "resp_data", resp_data,
          exp_hit ? dval(a) : 32'h0);
  endtask

  task automatic fill(logic [31:0] a);
    @(negedge clk);
    fill_valid = 1'b1; fill_data = dval(a);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(resp_valid === 1'b0, "R4", "resp_valid after reset", 32'(resp_valid), 0);
  endtask

  task automatic t_cold();
    lookup(32'h100, 0, 0, "R4/R7 cold miss way0");
    fill(32'h100);
    lookup(32'h100, 1, 0, "R8/R3 hit after fill");
    lookup(32'h103, 1, 0, "R1 byte offset ignored");
    @(negedge clk);
    check(resp_valid === 1'b0, "R9", "single-cycle resp_valid", 32'(resp_valid), 0);
  endtask

  task automatic t_replace();
    lookup(32'h200, 0, 1, "R7 invalid way preferred");
    fill(32'h200);
    lookup(32'h200, 1, 1, "R2 second tag way1");
    lookup(32'h100, 1, 0, "R2 first tag still way0");
    lookup(32'h300, 0, 1, "R6 LRU victim way1");
    fill(32'h300);
    lookup(32'h200, 0, 0, "R6/R5 evicted tag misses, victim way0");
    fill(32'h200);
    lookup(32'h300, 1, 1, "R5 filled line hits");
    lookup(32'h100, 0, 0, "R6 evicted tag misses");
    fill(32'h100);
  endtask

  task automatic t_other_set();
    lookup(32'h104, 0, 0, "R2 other set cold");
    fill(32'h104);
    lookup(32'h300, 1, 1, "R2 set0 undisturbed");
    lookup(32'h104, 1, 0, "R2 set1 hit");
  endtask

  task automatic t_ignore();
    lookup(32'h208, 0, 0, "R9 miss sets pending");
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h300;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid === 1'b0, "R9", "request during pending ignored", 32'(resp_valid), 0);
    fill(32'h208);
    lookup(32'h208, 1, 0, "R8 pending fill landed");
    fill(32'h20C); // no miss pending: must be ignored
    lookup(32'h20C, 0, 0, "R9 stray fill ignored");
    fill(32'h20C);
  endtask

  task automatic t_pingpong();
    int misses = 0;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a = (i % 2 == 0) ? 32'h0 : 32'h10;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      if (resp_valid && !resp_hit) begin
        misses++;
        fill(a);
      end
    end
    check(misses == 2, "R10", "ping-pong miss count", 32'(misses), 2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_cold();
    t_replace();
    t_other_set();
    t_ignore();
    t_pingpong();
    finish_run();
  end
endmodule